// File: doc/BRIEF.md
# Memory-Mapped Data Width Bridge

This block joins one memory-mapped master port to one slave port of a different data width. Both widths are a power-of-two number of bytes, chosen by parameters. Both sides use byte addresses, per-byte enables, and read, write, waitrequest and readdatavalid handshakes. Byte offset k of any word travels on data bits 8k+7 down to 8k on both sides, so a byte at a given address keeps the same lane position everywhere.

When the master is wider, the split engine breaks each master access into narrow slave beats. It sends the lowest-addressed beat first and gathers narrow read words back into one wide word. Its states are SP_IDLE (latch the request), SP_ISSUE (present one beat), SP_RDWAIT (await one narrow read word), SP_ACK (drop waitrequest for one cycle) and SP_RESP (pulse readdatavalid). Its transitions are IDLE→ISSUE on a request, ISSUE→ISSUE on an accepted or skipped write beat that is not the last, ISSUE→RDWAIT on an accepted read beat, RDWAIT→ISSUE on a returned word that is not the last, ISSUE/RDWAIT→ACK after the last beat, ACK→RESP for reads, ACK→IDLE for writes, and RESP→IDLE.

When the master is narrower, the steering engine places master data and enables on the slave lane group picked by the low address bits, and picks the same group out of read data. Its states are ST_IDLE (requests pass through) and ST_RDWAIT (one read outstanding, new requests held). The transitions are IDLE→RDWAIT on an accepted read and RDWAIT→IDLE on readdatavalid. When the two widths are equal, all signals pass straight through.

Top module: `mm_width_bridge`

## Requirements
- R1: After reset the bridge drives no slave read or write and no master readdatavalid.
- R2: On both ports byte offset k of a word is carried on bits 8k+7:8k, so a 32-bit master reading incrementing bytes 0,1,2,3 from address 0 sees 0x03020100.
- R3: A wide master access is split into narrow beats issued in ascending address order, lowest lanes first. Beat k uses slave address (master address with its low log2(master bytes) bits cleared) + k × slave bytes, and carries master enable and data slice k.
- R4: On a split write, a beat whose enable slice is all zero issues no slave cycle. A write with all enables zero is still accepted by the master port with no slave cycle at all.
- R5: On a split read, returned narrow word k is placed in master lane slice k of the gathered word.
- R6: During a split access, master waitrequest stays high until every slave beat has been accepted and, for reads, every narrow word has returned. Each master read gets exactly one readdatavalid pulse.
- R7: While the slave asserts waitrequest, the bridge holds the current beat's request, address and enables unchanged, and each beat is issued exactly once.
- R8: On the narrow-to-wide path, the slave address is the master address with its low log2(slave bytes) bits cleared. The master enables are shifted to the lane group numbered by the address bits between the two widths; with a 32-bit master and 64-bit slave, address 4 gives enables 11110000 and address 0 with enable 0001 gives 00000001.
- R9: On the narrow-to-wide path, read data returned to the master is the slave lane group chosen by the read's address.
- R10: Read data lanes whose master byte enable was zero are returned as zero on both paths.
- R11: While a narrow-to-wide read is outstanding, no new slave request is issued and the master's next request waits until the read data has returned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mst_addr | input | ADDR_W | Master byte address, aligned to the master word |
| mst_read | input | 1 | Master read request |
| mst_write | input | 1 | Master write request |
| mst_be | input | MST_BYTES | Master byte enables |
| mst_wdata | input | 8×MST_BYTES | Master write data |
| mst_wait | output | 1 | Master waitrequest |
| mst_rdata | output | 8×MST_BYTES | Master read data |
| mst_rvalid | output | 1 | Master readdatavalid |
| slv_addr | output | ADDR_W | Slave byte address, aligned to the slave word |
| slv_read | output | 1 | Slave read request |
| slv_write | output | 1 | Slave write request |
| slv_be | output | SLV_BYTES | Slave byte enables |
| slv_wdata | output | 8×SLV_BYTES | Slave write data |
| slv_wait | input | 1 | Slave waitrequest |
| slv_rdata | input | 8×SLV_BYTES | Slave read data |
| slv_rvalid | input | 1 | Slave readdatavalid |

## Verification
The hardest case to reach from the ports is a second master request that arrives while a narrow-to-wide read is still outstanding. A master that follows the handshake is normally stalled before it could issue one. The bench sets the slave model's read latency to several cycles and presents a write on the very next cycle after the read is accepted. It then confirms that readdatavalid arrives before the write is accepted and that the slave never saw a request during the wait. On the split path, the bench forces wait states and partial or empty enables, so that beat skipping and the hold of waitrequest until the last beat are both exercised.

// File: rtl/mm_width_pkg.sv
package mm_width_pkg;

    typedef enum logic [2:0] {
        SP_IDLE,
        SP_ISSUE,
        SP_RDWAIT,
        SP_ACK,
        SP_RESP
    } split_state_t;

    typedef enum logic {
        ST_IDLE,
        ST_RDWAIT
    } steer_state_t;

endpackage

// File: rtl/mm_lane_mask.sv
module mm_lane_mask #(
    parameter int NBYTES = 4
) (
    input  logic [NBYTES-1:0]   be,
    output logic [NBYTES*8-1:0] mask
);
    for (genvar i = 0; i < NBYTES; i++) begin : g_lane
        assign mask[i*8 +: 8] = {8{be[i]}};
    end
endmodule

// File: rtl/mm_width_split.sv
module mm_width_split
    import mm_width_pkg::*;
#(
    parameter int MB = 4,
    parameter int SB = 2,
    parameter int AW = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [AW-1:0]   m_addr,
    input  logic            m_read,
    input  logic            m_write,
    input  logic [MB-1:0]   m_be,
    input  logic [MB*8-1:0] m_wdata,
    output logic            m_wait,
    output logic [MB*8-1:0] m_rdata,
    output logic            m_rvalid,
    output logic [AW-1:0]   s_addr,
    output logic            s_read,
    output logic            s_write,
    output logic [SB-1:0]   s_be,
    output logic [SB*8-1:0] s_wdata,
    input  logic            s_wait,
    input  logic [SB*8-1:0] s_rdata,
    input  logic            s_rvalid
);
    localparam int RATIO  = MB / SB;
    localparam int BEAT_W = $clog2(RATIO);
    localparam int SLSB   = $clog2(SB);

    split_state_t      state;
    logic [BEAT_W-1:0] beat;
    logic [AW-1:0]     addr_q;
    logic [MB-1:0]     be_q;
    logic [MB*8-1:0]   wd_q;
    logic [MB*8-1:0]   rd_q;
    logic              is_rd;

    logic [SB-1:0]     be_slice;
    logic [SB*8-1:0]   wd_slice;
    logic [SB*8-1:0]   slice_mask;
    logic              last_beat;
    logic              skip_beat;

    assign be_slice  = be_q[int'(beat)*SB +: SB];
    assign wd_slice  = wd_q[int'(beat)*SB*8 +: SB*8];
    assign last_beat = (beat == BEAT_W'(RATIO - 1));
    assign skip_beat = !is_rd && (be_slice == '0);

    mm_lane_mask #(.NBYTES(SB)) u_slice_mask (
        .be   (be_slice),
        .mask (slice_mask)
    );

    // State register and captured request
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= SP_IDLE;
            beat   <= '0;
            addr_q <= '0;
            be_q   <= '0;
            wd_q   <= '0;
            rd_q   <= '0;
            is_rd  <= 1'b0;
        end else begin
            unique case (state)
                SP_IDLE: begin
                    if (m_read || m_write) begin
                        addr_q <= m_addr;
                        be_q   <= m_be;
                        wd_q   <= m_wdata;
                        is_rd  <= m_read;
                        rd_q   <= '0;
                        beat   <= '0;
                        state  <= SP_ISSUE;
                    end
                end
                SP_ISSUE: begin
                    if (skip_beat || !s_wait) begin
                        if (is_rd)          state <= SP_RDWAIT;
                        else if (last_beat) state <= SP_ACK;
                        else                beat  <= beat + 1'b1;
                    end
                end
                SP_RDWAIT: begin
                    if (s_rvalid) begin
                        rd_q[int'(beat)*SB*8 +: SB*8] <= s_rdata & slice_mask;
                        if (last_beat) begin
                            state <= SP_ACK;
                        end else begin
                            beat  <= beat + 1'b1;
                            state <= SP_ISSUE;
                        end
                    end
                end
                SP_ACK:  state <= is_rd ? SP_RESP : SP_IDLE;
                SP_RESP: state <= SP_IDLE;
                default: state <= SP_IDLE;
            endcase
        end
    end

    // Outputs
    always_comb begin
        s_read   = 1'b0;
        s_write  = 1'b0;
        m_wait   = 1'b1;
        m_rvalid = 1'b0;
        unique case (state)
            SP_ISSUE: begin
                s_read  = is_rd;
                s_write = !is_rd && !skip_beat;
            end
            SP_ACK:  m_wait   = 1'b0;
            SP_RESP: m_rvalid = 1'b1;
            default: ;
        endcase
    end

    assign s_addr  = (addr_q & ~AW'(MB - 1)) | (AW'(beat) << SLSB);
    assign s_be    = be_slice;
    assign s_wdata = wd_slice;
    assign m_rdata = rd_q;

endmodule

// File: rtl/mm_width_steer.sv
module mm_width_steer
    import mm_width_pkg::*;
#(
    parameter int MB = 4,
    parameter int SB = 8,
    parameter int AW = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [AW-1:0]   m_addr,
    input  logic            m_read,
    input  logic            m_write,
    input  logic [MB-1:0]   m_be,
    input  logic [MB*8-1:0] m_wdata,
    output logic            m_wait,
    output logic [MB*8-1:0] m_rdata,
    output logic            m_rvalid,
    output logic [AW-1:0]   s_addr,
    output logic            s_read,
    output logic            s_write,
    output logic [SB-1:0]   s_be,
    output logic [SB*8-1:0] s_wdata,
    input  logic            s_wait,
    input  logic [SB*8-1:0] s_rdata,
    input  logic            s_rvalid
);
    localparam int RATIO  = SB / MB;
    localparam int LANE_W = $clog2(RATIO);
    localparam int MLSB   = $clog2(MB);

    steer_state_t      state;
    logic [LANE_W-1:0] lane_in;
    logic [LANE_W-1:0] lane_q;
    logic [MB-1:0]     be_q;
    logic [MB*8-1:0]   rd_mask;

    assign lane_in = m_addr[MLSB +: LANE_W];

    mm_lane_mask #(.NBYTES(MB)) u_rd_mask (
        .be   (be_q),
        .mask (rd_mask)
    );

    // State register and lane of the outstanding read
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            lane_q <= '0;
            be_q   <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (m_read && !s_wait) begin
                        lane_q <= lane_in;
                        be_q   <= m_be;
                        state  <= ST_RDWAIT;
                    end
                end
                ST_RDWAIT: begin
                    if (s_rvalid) state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Outputs
    always_comb begin
        s_read   = 1'b0;
        s_write  = 1'b0;
        m_wait   = 1'b1;
        m_rvalid = 1'b0;
        unique case (state)
            ST_IDLE: begin
                s_read  = m_read;
                s_write = m_write;
                m_wait  = s_wait;
            end
            ST_RDWAIT: m_rvalid = s_rvalid;
            default: ;
        endcase
    end

    assign s_addr  = m_addr & ~AW'(SB - 1);
    assign s_be    = SB'(m_be) << (int'(lane_in) * MB);
    assign s_wdata = {RATIO{m_wdata}};
    assign m_rdata = s_rdata[int'(lane_q)*MB*8 +: MB*8] & rd_mask;

endmodule

// File: rtl/mm_width_bridge.sv
module mm_width_bridge #(
    parameter int ADDR_W    = 32,
    parameter int MST_BYTES = 4,
    parameter int SLV_BYTES = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [ADDR_W-1:0]      mst_addr,
    input  logic                   mst_read,
    input  logic                   mst_write,
    input  logic [MST_BYTES-1:0]   mst_be,
    input  logic [MST_BYTES*8-1:0] mst_wdata,
    output logic                   mst_wait,
    output logic [MST_BYTES*8-1:0] mst_rdata,
    output logic                   mst_rvalid,
    output logic [ADDR_W-1:0]      slv_addr,
    output logic                   slv_read,
    output logic                   slv_write,
    output logic [SLV_BYTES-1:0]   slv_be,
    output logic [SLV_BYTES*8-1:0] slv_wdata,
    input  logic                   slv_wait,
    input  logic [SLV_BYTES*8-1:0] slv_rdata,
    input  logic                   slv_rvalid
);
    if (MST_BYTES > SLV_BYTES) begin : g_split
        mm_width_split #(.MB(MST_BYTES), .SB(SLV_BYTES), .AW(ADDR_W)) u_split (
            .clk, .rst_n,
            .m_addr (mst_addr), .m_read (mst_read), .m_write (mst_write),
            .m_be (mst_be), .m_wdata (mst_wdata), .m_wait (mst_wait),
            .m_rdata (mst_rdata), .m_rvalid (mst_rvalid),
            .s_addr (slv_addr), .s_read (slv_read), .s_write (slv_write),
            .s_be (slv_be), .s_wdata (slv_wdata), .s_wait (slv_wait),
            .s_rdata (slv_rdata), .s_rvalid (slv_rvalid)
        );
    end else if (MST_BYTES < SLV_BYTES) begin : g_steer
        mm_width_steer #(.MB(MST_BYTES), .SB(SLV_BYTES), .AW(ADDR_W)) u_steer (
            .clk, .rst_n,
            .m_addr (mst_addr), .m_read (mst_read), .m_write (mst_write),
            .m_be (mst_be), .m_wdata (mst_wdata), .m_wait (mst_wait),
            .m_rdata (mst_rdata), .m_rvalid (mst_rvalid),
            .s_addr (slv_addr), .s_read (slv_read), .s_write (slv_write),
            .s_be (slv_be), .s_wdata (slv_wdata), .s_wait (slv_wait),
            .s_rdata (slv_rdata), .s_rvalid (slv_rvalid)
        );
    end else begin : g_pass
        assign slv_addr   = mst_addr;
        assign slv_read   = mst_read;
        assign slv_write  = mst_write;
        assign slv_be     = mst_be;
        assign slv_wdata  = mst_wdata;
        assign mst_wait   = slv_wait;
        assign mst_rdata  = slv_rdata;
        assign mst_rvalid = slv_rvalid;
    end
endmodule

// File: rtl/mm_width_bridge_chk.sv
module mm_width_bridge_chk #(
    parameter int MB = 4,
    parameter int SB = 2,
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic [MB-1:0] m_be,
    input logic          m_rvalid,
    input logic [AW-1:0] s_addr,
    input logic          s_read,
    input logic          s_write,
    input logic [SB-1:0] s_be,
    input logic          s_wait
);
    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        $rose(rst_n) |-> (!s_read && !s_write && !m_rvalid));

    // R6
    single_rvalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        m_rvalid |=> !m_rvalid);

    // R11
    no_req_at_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        m_rvalid |-> (!s_read && !s_write));

    // R7
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((s_read || s_write) && s_wait) |=>
            ((s_read || s_write) && $stable(s_addr) && $stable(s_be)));

    // R4
    write_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_write |-> (m_be != '0));

    if (MB > SB) begin : g_split_chk
        // R4
        no_empty_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
            s_write |-> (s_be != '0));
    end else if (MB < SB) begin : g_steer_chk
        // R8
        lane_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (s_write || s_read) |-> ($countones(s_be) == $countones(m_be)));
    end
endmodule

bind mm_width_bridge mm_width_bridge_chk #(
    .MB (MST_BYTES),
    .SB (SLV_BYTES),
    .AW (ADDR_W)
) u_mm_width_bridge_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .m_be     (mst_be),
    .m_rvalid (mst_rvalid),
    .s_addr   (slv_addr),
    .s_read   (slv_read),
    .s_write  (slv_write),
    .s_be     (slv_be),
    .s_wait   (slv_wait)
);

// File: tb/mm_width_bridge_bench.sv
module mm_bench_slave #(
    parameter int BYTES = 2
) (
    input  logic               clk,
    input  logic [7:0]         s_addr,
    input  logic               s_read,
    input  logic               s_write,
    input  logic [BYTES-1:0]   s_be,
    input  logic [BYTES*8-1:0] s_wdata,
    output logic               s_wait,
    output logic [BYTES*8-1:0] s_rdata,
    output logic               s_rvalid
);
    logic [7:0]         mem [64];
    logic [7:0]         log_addr [16];
    logic [7:0]         log_be [16];
    logic [BYTES*8-1:0] rbuf;
    int ws = 0;
    int rlat = 0;
    int wcnt = 0;
    int rcnt = 0;
    int nb = 0;
    int overlap = 0;

    initial begin
        for (int i = 0; i < 64; i++) mem[i] = 8'(i);
        s_wait = 1'b0; s_rvalid = 1'b0; s_rdata = '0; rbuf = '0;
        forever begin
            @(negedge clk);
            #2;
            s_rvalid = 1'b0;
            if (rcnt == 1) begin s_rvalid = 1'b1; s_rdata = rbuf; end
            if (rcnt > 0) rcnt--;
            if ((s_read || s_write) && rcnt != 0) overlap++;
            if (!(s_read || s_write)) begin
                s_wait = 1'b0; wcnt = 0;
            end else if (wcnt < ws) begin
                s_wait = 1'b1; wcnt++;
            end else begin
                s_wait = 1'b0; wcnt = 0;
                log_addr[nb % 16] = s_addr;
                log_be[nb % 16]   = 8'(s_be);
                nb++;
                if (s_write) begin
                    for (int i = 0; i < BYTES; i++)
                        if (s_be[i]) mem[(int'(s_addr) + i) % 64] = s_wdata[i*8 +: 8];
                end else begin
                    for (int i = 0; i < BYTES; i++)
                        rbuf[i*8 +: 8] = mem[(int'(s_addr) + i) % 64];
                    rcnt = rlat + 1;
                end
            end
        end
    end
endmodule

module mm_width_bridge_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b1;
    always #5 clk = ~clk;

    logic [7:0]  mst_addr [2];
    logic        mst_read [2];
    logic        mst_write [2];
    logic [3:0]  mst_be [2];
    logic [31:0] mst_wdata [2];
    logic [1:0]  mst_wait;
    logic [31:0] mst_rdata [2];
    logic [1:0]  mst_rvalid;

    logic [7:0]  s0_addr, s1_addr;
    logic        s0_read, s0_write, s1_read, s1_write;
    logic [1:0]  s0_be;
    logic [7:0]  s1_be;
    logic [15:0] s0_wdata, s0_rdata;
    logic [63:0] s1_wdata, s1_rdata;
    logic        s0_wait, s0_rvalid, s1_wait, s1_rvalid;

    int checks = 0;
    int fails = 0;
    bit acc_ok;
    int nb_at_acc;
    int rv_cnt;
    logic [31:0] rdat;

    mm_width_bridge #(.ADDR_W(8), .MST_BYTES(4), .SLV_BYTES(2)) u_mm_width_bridge (
        .clk, .rst_n,
        .mst_addr (mst_addr[0]), .mst_read (mst_read[0]), .mst_write (mst_write[0]),
        .mst_be (mst_be[0]), .mst_wdata (mst_wdata[0]), .mst_wait (mst_wait[0]),
        .mst_rdata (mst_rdata[0]), .mst_rvalid (mst_rvalid[0]),
        .slv_addr (s0_addr), .slv_read (s0_read), .slv_write (s0_write),
        .slv_be (s0_be), .slv_wdata (s0_wdata), .slv_wait (s0_wait),
        .slv_rdata (s0_rdata), .slv_rvalid (s0_rvalid)
    );

    mm_width_bridge #(.ADDR_W(8), .MST_BYTES(4), .SLV_BYTES(8)) u_mm_width_bridge_up (
        .clk, .rst_n,
        .mst_addr (mst_addr[1]), .mst_read (mst_read[1]), .mst_write (mst_write[1]),
        .mst_be (mst_be[1]), .mst_wdata (mst_wdata[1]), .mst_wait (mst_wait[1]),
        .mst_rdata (mst_rdata[1]), .mst_rvalid (mst_rvalid[1]),
        .slv_addr (s1_addr), .slv_read (s1_read), .slv_write (s1_write),
        .slv_be (s1_be), .slv_wdata (s1_wdata), .slv_wait (s1_wait),
        .slv_rdata (s1_rdata), .slv_rvalid (s1_rvalid)
    );

    mm_bench_slave #(.BYTES(2)) u_s0 (
        .clk, .s_addr (s0_addr), .s_read (s0_read), .s_write (s0_write),
        .s_be (s0_be), .s_wdata (s0_wdata), .s_wait (s0_wait),
        .s_rdata (s0_rdata), .s_rvalid (s0_rvalid)
    );

    mm_bench_slave #(.BYTES(8)) u_s1 (
        .clk, .s_addr (s1_addr), .s_read (s1_read), .s_write (s1_write),
        .s_be (s1_be), .s_wdata (s1_wdata), .s_wait (s1_wait),
        .s_rdata (s1_rdata), .s_rvalid (s1_rvalid)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic int get_nb(input int p);
        return (p == 1) ? u_s1.nb : u_s0.nb;
    endfunction

    task automatic clear_log(input int p);
        if (p == 1) begin u_s1.nb = 0; u_s1.overlap = 0; end
        else begin u_s0.nb = 0; u_s0.overlap = 0; end
    endtask

    task automatic wait_accept(input int p);
        int g = 0;
        acc_ok = 1'b0;
        while (g < 100) begin
            #3;
            if (!mst_wait[p]) begin acc_ok = 1'b1; break; end
            @(negedge clk);
            g++;
        end
        nb_at_acc = get_nb(p);
        if (!acc_ok) chk("R6 accept", 64'(acc_ok), 64'd1);
    endtask

    task automatic xfer(input int p, input bit rd, input logic [7:0] a,
                        input logic [3:0] be, input logic [31:0] wd);
        @(negedge clk);
        mst_addr[p] = a; mst_be[p] = be; mst_wdata[p] = wd;
        mst_read[p] = rd; mst_write[p] = !rd;
        wait_accept(p);
        @(negedge clk);
        mst_read[p] = 1'b0; mst_write[p] = 1'b0;
        rv_cnt = 0; rdat = '0;
        if (rd) begin
            for (int i = 0; i < 12; i++) begin
                #3;
                if (mst_rvalid[p]) begin rv_cnt++; rdat = mst_rdata[p]; end
                @(negedge clk);
            end
        end
    endtask

    task automatic t_reset();
        for (int p = 0; p < 2; p++) begin
            mst_addr[p] = '0; mst_read[p] = 1'b0; mst_write[p] = 1'b0;
            mst_be[p] = '0; mst_wdata[p] = '0;
        end
        #1 rst_n = 1'b0;
        repeat (3) @(negedge clk);
        #3;
        chk("R1 split slave read in reset", 64'(s0_read), 64'd0);
        chk("R1 split slave write in reset", 64'(s0_write), 64'd0);
        chk("R1 rvalid in reset", 64'(mst_rvalid), 64'd0);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        #3;
        chk("R1 slave idle after reset", 64'({s0_read, s0_write, s1_read, s1_write}), 64'd0);
    endtask

    task automatic t_split_read_full();
        u_s0.ws = 0; clear_log(0);
        xfer(0, 1'b1, 8'h00, 4'hF, 32'h0);
        chk("R2 R5 gathered word", 64'(rdat), 64'h03020100);
        chk("R6 one rvalid", 64'(rv_cnt), 64'd1);
        chk("R3 beat count", 64'(u_s0.nb), 64'd2);
        chk("R3 first beat low", 64'(u_s0.log_addr[0]), 64'h00);
        chk("R3 second beat", 64'(u_s0.log_addr[1]), 64'h02);
    endtask

    task automatic t_split_write_stall();
        u_s0.ws = 1; clear_log(0);
        xfer(0, 1'b0, 8'h08, 4'hF, 32'hAABBCCDD);
        chk("R6 all beats before accept", 64'(nb_at_acc), 64'd2);
        chk("R7 no repeated beat", 64'(u_s0.nb), 64'd2);
        chk("R3 beat order", 64'({u_s0.log_addr[0], u_s0.log_addr[1]}), 64'h080A);
        chk("R3 beat enables", 64'({u_s0.log_be[0], u_s0.log_be[1]}), 64'h0303);
        chk("R2 bytes in memory",
            64'({u_s0.mem[11], u_s0.mem[10], u_s0.mem[9], u_s0.mem[8]}), 64'hAABBCCDD);
    endtask

    task automatic t_split_write_skip();
        u_s0.ws = 0; clear_log(0);
        xfer(0, 1'b0, 8'h0C, 4'b1100, 32'h11220000);
        chk("R4 one beat issued", 64'(u_s0.nb), 64'd1);
        chk("R4 upper beat address", 64'(u_s0.log_addr[0]), 64'h0E);
        chk("R4 bytes written and kept",
            64'({u_s0.mem[15], u_s0.mem[14], u_s0.mem[13], u_s0.mem[12]}), 64'h11220D0C);
        clear_log(0);
        xfer(0, 1'b0, 8'h10, 4'b0000, 32'hFFFFFFFF);
        chk("R4 empty write accepted", 64'(acc_ok), 64'd1);
        chk("R4 empty write no beat", 64'(u_s0.nb), 64'd0);
        chk("R4 empty write no change", 64'(u_s0.mem[16]), 64'h10);
    endtask

    task automatic t_split_read_partial();
        u_s0.ws = 2; clear_log(0);
        xfer(0, 1'b1, 8'h08, 4'b0010, 32'h0);
        chk("R10 unenabled lanes zero", 64'(rdat), 64'h0000CC00);
        chk("R6 beats back before accept", 64'(nb_at_acc), 64'd2);
        chk("R6 one rvalid with stall", 64'(rv_cnt), 64'd1);
        u_s0.ws = 0;
    endtask

    task automatic t_steer_write();
        u_s1.ws = 0; clear_log(1);
        xfer(1, 1'b0, 8'h04, 4'hF, 32'h55667788);
        chk("R8 slave address aligned", 64'(u_s1.log_addr[0]), 64'h00);
        chk("R8 upper lane enables", 64'(u_s1.log_be[0]), 64'hF0);
        chk("R2 upper lane bytes",
            64'({u_s1.mem[7], u_s1.mem[6], u_s1.mem[5], u_s1.mem[4]}), 64'h55667788);
        clear_log(1);
        xfer(1, 1'b0, 8'h00, 4'b0001, 32'h000000EE);
        chk("R8 byte enable lane 0", 64'(u_s1.log_be[0]), 64'h01);
        chk("R8 single byte written", 64'({u_s1.mem[1], u_s1.mem[0]}), 64'h01EE);
    endtask

    task automatic t_steer_read();
        u_s1.ws = 1; clear_log(1);
        xfer(1, 1'b1, 8'h04, 4'hF, 32'h0);
        chk("R9 upper lane read", 64'(rdat), 64'h55667788);
        chk("R6 steer one rvalid", 64'(rv_cnt), 64'd1);
        clear_log(1);
        xfer(1, 1'b1, 8'h0C, 4'hF, 32'h0);
        chk("R8 read address cleared", 64'(u_s1.log_addr[0]), 64'h08);
        chk("R9 read second word", 64'(rdat), 64'h0F0E0D0C);
        xfer(1, 1'b1, 8'h00, 4'b0010, 32'h0);
        chk("R10 steer lane masking", 64'(rdat), 64'h00000100);
        u_s1.ws = 0;
    endtask

    task automatic t_steer_hold();
        bit seen_rv = 1'b0;
        logic [31:0] rd_val = '0;
        int g = 0;
        u_s1.rlat = 3; clear_log(1);
        @(negedge clk);
        mst_addr[1] = 8'h10; mst_be[1] = 4'hF; mst_read[1] = 1'b1; mst_write[1] = 1'b0;
        wait_accept(1);
        @(negedge clk);
        mst_read[1] = 1'b0; mst_write[1] = 1'b1;
        mst_addr[1] = 8'h20; mst_wdata[1] = 32'hCAFEF00D;
        acc_ok = 1'b0;
        while (g < 100) begin
            #3;
            if (mst_rvalid[1]) begin seen_rv = 1'b1; rd_val = mst_rdata[1]; end
            if (!mst_wait[1]) begin acc_ok = 1'b1; break; end
            @(negedge clk);
            g++;
        end
        @(negedge clk);
        mst_write[1] = 1'b0;
        chk("R11 data back before next accept", 64'({seen_rv, acc_ok}), 64'b11);
        chk("R11 no slave request while waiting", 64'(u_s1.overlap), 64'd0);
        chk("R9 delayed read data", 64'(rd_val), 64'h13121110);
        u_s1.rlat = 0;
        xfer(1, 1'b1, 8'h20, 4'hF, 32'h0);
        chk("R11 held write landed", 64'(rdat), 64'hCAFEF00D);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        #1_000_000;
        chk("R6 watchdog expired", 64'd1, 64'd0);
        finish_run();
    end

    initial begin
        t_reset();
        t_split_read_full();
        t_split_write_stall();
        t_split_write_skip();
        t_split_read_partial();
        t_steer_write();
        t_steer_read();
        t_steer_hold();
        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule